// File: doc/BRIEF.md
# Two-Channel Host Bus Front End with Priority Interrupt Chain

This block is the processor-facing side of a two-channel serial controller. It runs on one system clock. It turns active-low select, read and write strobes into register transfers, and it uses a channel select and a data/control select to steer each transfer. Each channel holds a data holding register and a six-bit control register. A command field in control writes gives access to a shared interrupt vector base and to the release of an interrupt in service.

Each channel has one receive request source. A pending receive request whose enable bit is set raises the active-low interrupt request. The interrupt request stays raised only while no channel is in service. The block sits in a priority chain with an enable input from the higher-priority neighbour and an enable output to the lower-priority one. During an acknowledge cycle the granted device places a vector on the bus. The vector carries the source in three of its bits. The bus is modelled as separate input data, output data and output enable.

Top module: `sbi_top`

## Requirements
- R1: Holding `rstN` low, or holding `rdN` and `wrN` low together during any clock, clears the data registers, control registers, vector base, pending flags and in-service flags. After such a reset `intN` is 1, `dOe` is 0 and `dOut` is 0.
- R2: A falling write strobe while `ceN` is low stores `dIn` in one register. `chanA`=1 selects channel A and `chanA`=0 selects channel B. `dataSel`=1 selects the data register and `dataSel`=0 selects the control register. A write while `ceN` is high changes nothing.
- R3: A falling read strobe while `ceN` is low sets `dOe` at the next clock edge. `dOut` then holds the data register, or for a control read the byte {pending, in-service, control[5:0]}. At the first edge after `rdN` rises, `dOe` and `dOut` return to 0.
- R4: A control write is decoded by bits [7:6]. 00 stores bits [5:0], and bit 0 is the receive interrupt enable. 10 arms a load, so that the next control write on either channel becomes the whole vector base. 11 clears the in-service flag of the highest-priority channel in service. 01 does nothing.
- R5: `rxReq[0]` (channel A) or `rxReq[1]` (channel B) high at a clock edge sets that channel's pending flag. A register read of that channel's data register clears it.
- R6: `intN` is 0 exactly when some channel is both pending and enabled and no channel is in service.
- R7: `intackN` is registered on the clock. With the registered acknowledge active, a falling `rdN` (regardless of `ceN`) while `ieiIn`=1 and `intN`=0 is an accepted acknowledge. `dOut` then becomes (base & 8'hF1) | (code << 1), where code is 3'b100 for channel A and 3'b000 for channel B. Channel A wins when both request. That channel's in-service flag is set, and no register read occurs.
- R8: An acknowledge read while `ieiIn`=0 or while `intN`=1 leaves `dOe` at 0 and leaves every in-service flag unchanged.
- R9: `ieoOut` is 1 only when `ieiIn`=1, no channel is in service, and not both (registered acknowledge active and `intN`=0).
- R10: When `rdN` and `wrN` fall in the same clock, no register is written and no read data is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| chanA | input | 1 | 1 = channel A, 0 = channel B |
| dataSel | input | 1 | 1 = data register, 0 = control register |
| dIn | input | 8 | Write data from host |
| dOut | output | 8 | Read data or vector to host |
| dOe | output | 1 | Output enable of the bus driver |
| intackN | input | 1 | Interrupt acknowledge, active low |
| ieiIn | input | 1 | Chain enable from higher-priority device |
| ieoOut | output | 1 | Chain enable to lower-priority device |
| intN | output | 1 | Interrupt request, active low, open-drain style |
| rxReq | input | 2 | Receive request per channel (bit 0 = A) |

## Verification
The vector base is swept over all 256 values with both channels requesting at once, and both acknowledge vectors are checked each time. A design that dropped the base bits, put the source code at the wrong position, or let channel B win would give wrong vectors. An acknowledge with the chain input low, and another with no request, must leave the bus undriven and set no in-service flag; a design that ignored the chain gating would drive a vector there. Reads and writes with both strobes low together must clear the registers without storing the write data, and a write with the chip select high must be ignored. The enable output is checked while idle, while an acknowledge is pending and while a channel is in service, which catches a missing term in its gating.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 2;
  localparam int CTRL_W = DATA_W - 2;
  localparam int CODE_W = 3;
  localparam int IDX_W  = $clog2(NUM_CH);

  typedef logic [IDX_W-1:0] chIdx_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic   regWr;
    logic   regRd;
    logic   ackGrant;
    logic   rdDone;
    logic   softReset;
    logic   ackPhase;
    logic   dataSel;
    chIdx_t chan;
  } busStrobe_t;

  // source code placed into vector bits [3:1]
  function automatic logic [CODE_W-1:0] chanCode(input chIdx_t c);
    return (c == chIdx_t'(0)) ? 3'b100 : 3'b000;
  endfunction
endpackage

// File: rtl/sbi_ctrl.sv
module sbi_ctrl
  import sbi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       chanA,
  input  logic       dataSel,
  input  logic       intackN,
  input  logic       ieiIn,
  input  logic       intActive,
  output busStrobe_t stb,
  output logic       dOe
);
  logic ackQ;
  logic rdPrev, wrPrev;
  logic rdAct, wrAct, bothLow;
  logic rdStart, wrStart;

  assign bothLow = ~rdN & ~wrN;
  assign rdAct   = ~rdN & (~ceN | ackQ);
  assign wrAct   = ~wrN & ~ceN;
  assign rdStart = rdAct & ~rdPrev & wrN;
  assign wrStart = wrAct & ~wrPrev & rdN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ   <= 1'b0;
      rdPrev <= 1'b0;
      wrPrev <= 1'b0;
    end else begin
      ackQ   <= ~intackN;
      rdPrev <= rdAct;
      wrPrev <= wrAct;
    end
  end

  always_comb begin
    stb           = '0;
    stb.softReset = bothLow;
    stb.ackPhase  = ackQ;
    stb.dataSel   = dataSel;
    stb.chan      = chanA ? chIdx_t'(0) : chIdx_t'(1);
    stb.regWr     = wrStart;
    stb.regRd     = rdStart & ~ackQ;
    stb.ackGrant  = rdStart & ackQ & ieiIn & intActive;
    stb.rdDone    = ~rdAct;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dOe <= 1'b0;
    end else if (bothLow || !rdAct) begin
      dOe <= 1'b0;
    end else if (stb.regRd || stb.ackGrant) begin
      dOe <= 1'b1;
    end
  end

  // R3: driver only on while the read strobe was low at the last edge
  p_oe_needs_rd_r3: assert property (@(posedge clk) disable iff (!rstN)
    dOe |-> $past(!rdN));
  // R1: strobe clash releases the bus
  p_clash_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !wrN) |=> !dOe);
  // R8: acknowledge with chain input low never drives
  p_ack_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdStart && ackQ && !ieiIn) |=> !dOe);
endmodule

// File: rtl/sbi_dp.sv
module sbi_dp
  import sbi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        stb,
  input  logic [DATA_W-1:0] dIn,
  input  logic [NUM_CH-1:0] rxReq,
  input  logic              ieiIn,
  output logic              intActive,
  output logic [DATA_W-1:0] dOut,
  output logic              ieoOut,
  output logic              intN
);
  localparam logic [1:0] CMD_STORE = 2'b00;
  localparam logic [1:0] CMD_ARM   = 2'b10;
  localparam logic [1:0] CMD_RSIUS = 2'b11;

  logic [DATA_W-1:0] dataReg [NUM_CH];
  logic [CTRL_W-1:0] ctrlReg [NUM_CH];
  logic [NUM_CH-1:0] pend, ius, req, iusClr, higherIus;
  logic [DATA_W-1:0] vecBase;
  logic              vecArm;
  logic              ctrlWr, cmdStore, cmdRsIus;
  chIdx_t            winner;
  logic [DATA_W-1:0] vector;

  assign ctrlWr   = stb.regWr & ~stb.dataSel & ~stb.softReset;
  assign cmdStore = ctrlWr & ~vecArm & (dIn[DATA_W-1 -: 2] == CMD_STORE);
  assign cmdRsIus = ctrlWr & ~vecArm & (dIn[DATA_W-1 -: 2] == CMD_RSIUS);

  // priority: lower index (channel A) first
  always_comb begin
    higherIus = '0;
    for (int i = 1; i < NUM_CH; i++) higherIus[i] = higherIus[i-1] | ius[i-1];
    winner = chIdx_t'(NUM_CH - 1);
    for (int i = NUM_CH - 1; i >= 0; i--) if (req[i]) winner = chIdx_t'(i);
  end

  assign iusClr    = {NUM_CH{cmdRsIus}} & ~higherIus;
  assign intActive = (|req) & ~(|ius);
  assign intN      = ~intActive;
  assign ieoOut    = ieiIn & ~(|ius) & ~(stb.ackPhase & intActive);
  assign vector    = {vecBase[DATA_W-1:4], chanCode(winner), vecBase[0]};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic hit;
    assign hit    = (stb.chan == chIdx_t'(g));
    assign req[g] = pend[g] & ctrlReg[g][0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataReg[g] <= '0;
        ctrlReg[g] <= '0;
        pend[g]    <= 1'b0;
        ius[g]     <= 1'b0;
      end else if (stb.softReset) begin
        dataReg[g] <= '0;
        ctrlReg[g] <= '0;
        pend[g]    <= 1'b0;
        ius[g]     <= 1'b0;
      end else begin
        if (stb.regWr && stb.dataSel && hit) dataReg[g] <= dIn;
        if (cmdStore && hit) ctrlReg[g] <= dIn[CTRL_W-1:0];
        if (rxReq[g]) pend[g] <= 1'b1;
        else if (stb.regRd && stb.dataSel && hit) pend[g] <= 1'b0;
        if (stb.ackGrant && winner == chIdx_t'(g)) ius[g] <= 1'b1;
        else if (iusClr[g]) ius[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecBase <= '0;
      vecArm  <= 1'b0;
    end else if (stb.softReset) begin
      vecBase <= '0;
      vecArm  <= 1'b0;
    end else if (ctrlWr) begin
      if (vecArm) begin
        vecBase <= dIn;
        vecArm  <= 1'b0;
      end else if (dIn[DATA_W-1 -: 2] == CMD_ARM) begin
        vecArm <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dOut <= '0;
    end else if (stb.softReset || stb.rdDone) begin
      dOut <= '0;
    end else if (stb.ackGrant) begin
      dOut <= vector;
    end else if (stb.regRd) begin
      dOut <= stb.dataSel ? dataReg[stb.chan]
                          : {pend[stb.chan], ius[stb.chan], ctrlReg[stb.chan]};
    end
  end

  // R7: at most one channel in service
  p_ius_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ius));
  // R7: an accepted acknowledge leaves a channel in service
  p_grant_sets_ius_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackGrant && !stb.softReset) |=> (|ius));
  // R6: no request while any channel is in service
  p_int_blocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|ius) |-> intN);
  // R9: service blocks the chain
  p_ieo_serv_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|ius) |-> !ieoOut);
endmodule

// File: rtl/sbi_top.sv
module sbi_top
  import sbi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              chanA,
  input  logic              dataSel,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe,
  input  logic              intackN,
  input  logic              ieiIn,
  output logic              ieoOut,
  output logic              intN,
  input  logic [NUM_CH-1:0] rxReq
);
  busStrobe_t stb;
  logic       intActive;

  sbi_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .rdN(rdN), .wrN(wrN),
    .chanA(chanA), .dataSel(dataSel), .intackN(intackN), .ieiIn(ieiIn),
    .intActive(intActive), .stb(stb), .dOe(dOe)
  );

  sbi_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .dIn(dIn), .rxReq(rxReq),
    .ieiIn(ieiIn), .intActive(intActive), .dOut(dOut), .ieoOut(ieoOut),
    .intN(intN)
  );
endmodule

// File: tb/sbi_top_tb_top.sv
module sbi_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, rdN = 1'b1, wrN = 1'b1, chanA = 1'b1, dataSel = 1'b1;
  logic [7:0] dIn = 8'h00;
  logic [7:0] dOut;
  logic dOe, intackN = 1'b1, ieiIn = 1'b1, ieoOut, intN;
  logic [1:0] rxReq = 2'b00;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sbi_top dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .rdN(rdN), .wrN(wrN), .chanA(chanA),
    .dataSel(dataSel), .dIn(dIn), .dOut(dOut), .dOe(dOe), .intackN(intackN),
    .ieiIn(ieiIn), .ieoOut(ieoOut), .intN(intN), .rxReq(rxReq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic a, input logic d, input logic [7:0] v, input logic ce = 1'b0);
    @(negedge clk); ceN = ce; chanA = a; dataSel = d; dIn = v; wrN = 1'b0;
    @(negedge clk); @(negedge clk); wrN = 1'b1; ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busRd(input logic a, input logic d, output logic [7:0] v, output logic oe);
    @(negedge clk); ceN = 1'b0; chanA = a; dataSel = d; rdN = 1'b0;
    @(negedge clk); v = dOut; oe = dOe;
    @(negedge clk); rdN = 1'b1; ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic ackRd(output logic [7:0] v, output logic oe);
    @(negedge clk); intackN = 1'b0;
    @(negedge clk); rdN = 1'b0;
    @(negedge clk); v = dOut; oe = dOe;
    @(negedge clk); rdN = 1'b1;
    @(negedge clk); intackN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseRx(input logic [1:0] m);
    @(negedge clk); rxReq = m;
    @(negedge clk); rxReq = 2'b00;
  endtask

  task automatic loadBase(input logic [7:0] b);
    busWr(1'b1, 1'b0, 8'h80);
    busWr(1'b0, 1'b0, b);
  endtask

  function automatic logic [7:0] expVec(input logic [7:0] b, input logic isA);
    return (b & 8'hF1) | ((isA ? 8'd4 : 8'd0) << 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic oe;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 intN after reset", {7'd0, intN}, 8'd1);
    chk("R1 dOe after reset", {7'd0, dOe}, 8'd0);
    chk("R1 dOut after reset", dOut, 8'd0);
    chk("R9 ieo idle", {7'd0, ieoOut}, 8'd1);

    // R2 / R3 all four registers
    for (int p = 0; p < 4; p++) begin
      logic [7:0] val;
      val = 8'h11 * (p + 3);
      if (p >= 2) val = val & 8'h3E;
      busWr(p[0], ~p[1], val);
    end
    for (int p = 0; p < 4; p++) begin
      logic [7:0] val;
      val = 8'h11 * (p + 3);
      if (p >= 2) val = val & 8'h3E;
      busRd(p[0], ~p[1], v, oe);
      chk("R2 register readback", v, val);
      chk("R3 dOe during read", {7'd0, oe}, 8'd1);
      chk("R3 dOe released", {7'd0, dOe}, 8'd0);
      chk("R3 dOut released", dOut, 8'd0);
    end

    // R2 write with ceN high ignored
    busWr(1'b1, 1'b1, 8'hE7, 1'b1);
    busRd(1'b1, 1'b1, v, oe);
    chk("R2 deselected write ignored", v, 8'h44);

    // R4 / R5 / R6 enable and pend
    busWr(1'b1, 1'b0, 8'h01);
    busWr(1'b0, 1'b0, 8'h01);
    chk("R6 no pend no int", {7'd0, intN}, 8'd1);
    pulseRx(2'b01);
    chk("R6 int on pend", {7'd0, intN}, 8'd0);
    busRd(1'b1, 1'b0, v, oe);
    chk("R5 ctrl read shows pend", v, 8'h81);
    chk("R9 ieo high no ack", {7'd0, ieoOut}, 8'd1);
    @(negedge clk); intackN = 1'b0;
    @(negedge clk);
    chk("R9 ieo low ack and req", {7'd0, ieoOut}, 8'd0);
    intackN = 1'b1;
    @(negedge clk);

    // R8 chain input low
    ieiIn = 1'b0;
    ackRd(v, oe);
    chk("R8 no drive with iei low", {7'd0, oe}, 8'd0);
    ieiIn = 1'b1;
    busRd(1'b1, 1'b0, v, oe);
    chk("R8 ius untouched", v, 8'h81);

    // R7 single acknowledge, R9 during service, R4 release
    loadBase(8'h0E);
    ackRd(v, oe);
    chk("R7 vector A base 0E", v, expVec(8'h0E, 1'b1));
    chk("R7 vector drives", {7'd0, oe}, 8'd1);
    chk("R9 ieo low in service", {7'd0, ieoOut}, 8'd0);
    chk("R6 int masked in service", {7'd0, intN}, 8'd1);
    busRd(1'b1, 1'b0, v, oe);
    chk("R7 ius set", v, 8'hC1);
    busRd(1'b1, 1'b1, v, oe);
    busRd(1'b1, 1'b0, v, oe);
    chk("R5 data read clears pend", v, 8'h41);
    busWr(1'b1, 1'b0, 8'hC0);
    busRd(1'b1, 1'b0, v, oe);
    chk("R4 reset in service", v, 8'h01);
    chk("R9 ieo back high", {7'd0, ieoOut}, 8'd1);

    // R8 no request
    ackRd(v, oe);
    chk("R8 no drive without request", {7'd0, oe}, 8'd0);

    // R7 sweep of vector base, both channels
    for (int b = 0; b < 256; b++) begin
      loadBase(b[7:0]);
      pulseRx(2'b11);
      ackRd(v, oe);
      chk("R7 sweep vector A", v, expVec(b[7:0], 1'b1));
      busWr(1'b1, 1'b0, 8'hC0);
      busRd(1'b1, 1'b1, v, oe);
      ackRd(v, oe);
      chk("R7 sweep vector B", v, expVec(b[7:0], 1'b0));
      busWr(1'b0, 1'b0, 8'hC0);
      busRd(1'b0, 1'b1, v, oe);
    end
    chk("R6 sweep ends idle", {7'd0, intN}, 8'd1);

    // R10 / R1 strobe clash
    busWr(1'b1, 1'b1, 8'h55);
    pulseRx(2'b01);
    @(negedge clk); ceN = 1'b0; chanA = 1'b1; dataSel = 1'b1; dIn = 8'hAA;
    rdN = 1'b0; wrN = 1'b0;
    @(negedge clk);
    chk("R10 no drive on clash", {7'd0, dOe}, 8'd0);
    rdN = 1'b1; wrN = 1'b1; ceN = 1'b1;
    @(negedge clk);
    chk("R1 int cleared by clash", {7'd0, intN}, 8'd1);
    busRd(1'b1, 1'b1, v, oe);
    chk("R10 clash stored nothing", v, 8'h00);
    busRd(1'b1, 1'b0, v, oe);
    chk("R1 ctrl cleared", v, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule